// File: doc/BRIEF.md
# Signed Halfword Load Execution Unit

This unit carries out one load of a signed 16-bit value from memory. A decoder hands it the destination index, the base index, a 12-bit immediate, the addressing form, the width bit and the current privilege level. The unit reads the base from an external register file, or from the stack pointer when the base index is all ones. It forms the access address and issues a single 2-byte read request. The request carries two attributes: privileged and tag-checked. When the one-beat response arrives, the unit sign-extends the halfword to the selected width. In that same cycle it writes the result to the destination register and, for the indexed forms, writes the updated address back to the base.

There are three addressing forms. Each scales the immediate differently and has its own writeback rule. One case is handled by a parameter: an indexed form whose base register is also the destination. The parameter chooses one of four policies: drop the writeback, write a fixed all-ones pattern, raise an undefined-instruction fault, or retire the operation as a no-op. A stack pointer base that is not 16-byte aligned raises an alignment fault instead of an access.

Top module: `shload_unit`

## Requirements
- R1: The form code `op_form` selects the access address. For 2'b00 (post-index) it is the base. For 2'b01 (pre-index) and 2'b10 (unsigned offset) it is base plus offset.
- R2: For 2'b00 and 2'b01, the offset is `op_imm[8:0]` read as a signed value (-256..255) and sign-extended to 64 bits. Bits 11:9 are ignored. For 2'b10, the offset is `op_imm` times two (0..8190).
- R3: The destination write carries the sign-extended halfword. When `op_narrow` is 0 it is extended to 64 bits. When `op_narrow` is 1 it is extended to 32 bits, and bits 63:32 are zero.
- R4: Forms 2'b00 and 2'b01 write base plus offset back to the base. Form 2'b10 writes nothing back.
- R5: Base index 31 reads `sp_rdata`, and any writeback goes out on `sp_we`/`sp_wdata`, never on the general write-back port.
- R6: When the base index is 31 and stack pointer bits 3:0 are not all zero, the unit raises `fault_align` with `done`. It makes no memory request and no register write.
- R7: `mem_req_tag` is 1 when the form is indexed or the base index is not 31. Otherwise it is 0.
- R8: `mem_req_priv` is 1 exactly when `op_el` is nonzero.
- R9: Overlap means an indexed form with base index equal to destination index and not 31. Under policy 0 an overlap still writes the destination but writes nothing back.
- R10: Under policy 1 an overlap writes all ones back to the base register.
- R11: Under policy 2 an overlap raises `fault_undef` with `done`. It makes no request and no write.
- R12: Under policy 3 an overlap retires with `done` alone: no fault, no request, no write.
- R13: `op_ready` is low from acceptance to completion. A request stays asserted with a stable address until `mem_req_ready`. `done` and all register writes occur only in the cycle `mem_rsp_valid` is high (or in the cycle after acceptance for a fault or no-op).
- R14: During reset the unit is idle: `op_ready` is high, and there is no request, no `done` and no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Decoded operation present |
| op_ready | output | 1 | Unit idle, operation accepted |
| op_rt | input | 5 | Destination register index |
| op_rn | input | 5 | Base register index, 31 = stack pointer |
| op_imm | input | 12 | Immediate field |
| op_form | input | 2 | 00 post-index, 01 pre-index, 10 unsigned offset |
| op_narrow | input | 1 | 1 = 32-bit destination, 0 = 64-bit |
| op_el | input | 2 | Current privilege level |
| rf_raddr | output | 5 | Register file read index |
| rf_rdata | input | 64 | Register file read data |
| sp_rdata | input | 64 | Stack pointer value |
| mem_req_valid | output | 1 | Read request |
| mem_req_ready | input | 1 | Request accepted |
| mem_req_addr | output | 64 | Byte address of the halfword |
| mem_req_priv | output | 1 | Privileged access attribute |
| mem_req_tag | output | 1 | Tag-checked access attribute |
| mem_rsp_valid | input | 1 | Response beat |
| mem_rsp_data | input | 16 | Loaded halfword |
| rf_we | output | 1 | Destination write enable |
| rf_waddr | output | 5 | Destination index |
| rf_wdata | output | 64 | Extended result |
| wb_we | output | 1 | Base register write-back enable |
| wb_waddr | output | 5 | Base register index |
| wb_wdata | output | 64 | Write-back address value |
| sp_we | output | 1 | Stack pointer write enable |
| sp_wdata | output | 64 | New stack pointer value |
| done | output | 1 | Operation retired |
| fault_align | output | 1 | Stack pointer alignment fault |
| fault_undef | output | 1 | Undefined-instruction fault |

## Verification
The bench builds four copies of the unit, one for each overlap policy value 0 to 3. All four see the same operations and the same memory timing. A single overlapping operation therefore shows, side by side, a dropped writeback, an all-ones writeback, an undefined fault and a silent retire. Only the policy-0 copy exercises the memory handshake with random stalls and response latencies of one to three cycles. The other three inherit that timing, so the all-ones writeback lands in the same cycle as the destination write.

// File: rtl/shl_pkg.sv
package shl_pkg;
  localparam int XLEN = 64;

  typedef enum logic [1:0] {
    FORM_POST = 2'b00,
    FORM_PRE  = 2'b01,
    FORM_UOFF = 2'b10,
    FORM_RSVD = 2'b11
  } form_e;

  typedef enum logic [1:0] {
    OVL_SUPPRESS = 2'd0,
    OVL_UNKNOWN  = 2'd1,
    OVL_UNDEF    = 2'd2,
    OVL_NOP      = 2'd3
  } ovl_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_FIN
  } state_e;

  // Byte offset implied by the form: signed 9-bit for indexed forms,
  // unsigned 12-bit scaled by the halfword size otherwise.
  function automatic logic [XLEN-1:0] form_offset(logic [1:0] form, logic [11:0] imm);
    if (form == FORM_POST || form == FORM_PRE)
      return {{(XLEN-9){imm[8]}}, imm[8:0]};
    return {{(XLEN-13){1'b0}}, imm, 1'b0};
  endfunction

  // Replicate the halfword sign bit; a narrow result clears the upper half.
  function automatic logic [XLEN-1:0] widen_half(logic [15:0] h, logic narrow);
    logic [XLEN-1:0] full;
    full = {{(XLEN-16){h[15]}}, h};
    if (narrow) full[XLEN-1:XLEN/2] = '0;
    return full;
  endfunction
endpackage

// File: rtl/shl_agen.sv
module shl_agen
  import shl_pkg::*;
#(
  parameter int IDX_W      = 5,
  parameter int ALIGN_BITS = 4
) (
  input  logic [1:0]       form,
  input  logic [11:0]      imm,
  input  logic [IDX_W-1:0] rn,
  input  logic [IDX_W-1:0] rt,
  input  logic [1:0]       el,
  input  logic [XLEN-1:0]  gpr_val,
  input  logic [XLEN-1:0]  sp_val,
  output logic [XLEN-1:0]  acc_addr,
  output logic [XLEN-1:0]  upd_addr,
  output logic             wback,
  output logic             sp_sel,
  output logic             tag_chk,
  output logic             priv,
  output logic             misalign,
  output logic             overlap
);
  localparam logic [IDX_W-1:0] SP_IDX = '1;

  logic [XLEN-1:0] base;
  logic [XLEN-1:0] offs;

  assign sp_sel   = (rn == SP_IDX);
  assign base     = sp_sel ? sp_val : gpr_val;
  assign offs     = form_offset(form, imm);
  assign upd_addr = base + offs;
  assign wback    = (form == FORM_POST) || (form == FORM_PRE);
  assign acc_addr = (form == FORM_POST) ? base : upd_addr;
  assign tag_chk  = wback || !sp_sel;
  assign priv     = (el != 2'd0);
  assign misalign = sp_sel && (|base[ALIGN_BITS-1:0]);
  assign overlap  = wback && (rn == rt) && !sp_sel;
endmodule

// File: rtl/shl_policy.sv
module shl_policy
  import shl_pkg::*;
#(
  parameter logic [1:0] POLICY = 2'd0
) (
  input  logic            overlap,
  input  logic            wback,
  input  logic [XLEN-1:0] upd_addr,
  output logic            do_wb,
  output logic [XLEN-1:0] wb_value,
  output logic            undef_hit,
  output logic            nop_hit
);
  generate
    if (POLICY == OVL_SUPPRESS) begin : g_suppress
      assign do_wb     = wback && !overlap;
      assign wb_value  = upd_addr;
      assign undef_hit = 1'b0;
      assign nop_hit   = 1'b0;
    end else if (POLICY == OVL_UNKNOWN) begin : g_unknown
      assign do_wb     = wback;
      assign wb_value  = overlap ? '1 : upd_addr;
      assign undef_hit = 1'b0;
      assign nop_hit   = 1'b0;
    end else if (POLICY == OVL_UNDEF) begin : g_undef
      assign do_wb     = wback;
      assign wb_value  = upd_addr;
      assign undef_hit = overlap;
      assign nop_hit   = 1'b0;
    end else begin : g_nop
      assign do_wb     = wback;
      assign wb_value  = upd_addr;
      assign undef_hit = 1'b0;
      assign nop_hit   = overlap;
    end
  endgenerate
endmodule

// File: rtl/shl_extend.sv
module shl_extend
  import shl_pkg::*;
(
  input  logic [15:0]     half,
  input  logic            narrow,
  output logic [XLEN-1:0] value
);
  assign value = widen_half(half, narrow);
endmodule

// File: rtl/shload_unit.sv
module shload_unit
  import shl_pkg::*;
#(
  parameter int         IDX_W          = 5,
  parameter int         ALIGN_BITS     = 4,
  parameter logic [1:0] OVERLAP_POLICY = 2'd0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  output logic             op_ready,
  input  logic [IDX_W-1:0] op_rt,
  input  logic [IDX_W-1:0] op_rn,
  input  logic [11:0]      op_imm,
  input  logic [1:0]       op_form,
  input  logic             op_narrow,
  input  logic [1:0]       op_el,
  output logic [IDX_W-1:0] rf_raddr,
  input  logic [XLEN-1:0]  rf_rdata,
  input  logic [XLEN-1:0]  sp_rdata,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [XLEN-1:0]  mem_req_addr,
  output logic             mem_req_priv,
  output logic             mem_req_tag,
  input  logic             mem_rsp_valid,
  input  logic [15:0]      mem_rsp_data,
  output logic             rf_we,
  output logic [IDX_W-1:0] rf_waddr,
  output logic [XLEN-1:0]  rf_wdata,
  output logic             wb_we,
  output logic [IDX_W-1:0] wb_waddr,
  output logic [XLEN-1:0]  wb_wdata,
  output logic             sp_we,
  output logic [XLEN-1:0]  sp_wdata,
  output logic             done,
  output logic             fault_align,
  output logic             fault_undef
);
  // Combinational decision on the operation being offered
  logic [XLEN-1:0] a_acc, a_upd, p_wbval;
  logic a_wback, a_spsel, a_tag, a_priv, a_misalign, a_overlap;
  logic p_dowb, p_undef, p_nop;

  // Named events, also observed by the checker
  logic accept;
  logic trap_hit;
  logic commit;

  // Captured operation
  state_e           state;
  logic [XLEN-1:0]  q_addr, q_wbval;
  logic [IDX_W-1:0] q_rt, q_rn;
  logic q_dowb, q_spsel, q_narrow, q_priv, q_tag, q_falign, q_fundef;

  assign rf_raddr = op_rn;

  shl_agen #(.IDX_W(IDX_W), .ALIGN_BITS(ALIGN_BITS)) u_agen (
    .form     (op_form),
    .imm      (op_imm),
    .rn       (op_rn),
    .rt       (op_rt),
    .el       (op_el),
    .gpr_val  (rf_rdata),
    .sp_val   (sp_rdata),
    .acc_addr (a_acc),
    .upd_addr (a_upd),
    .wback    (a_wback),
    .sp_sel   (a_spsel),
    .tag_chk  (a_tag),
    .priv     (a_priv),
    .misalign (a_misalign),
    .overlap  (a_overlap)
  );

  shl_policy #(.POLICY(OVERLAP_POLICY)) u_policy (
    .overlap   (a_overlap),
    .wback     (a_wback),
    .upd_addr  (a_upd),
    .do_wb     (p_dowb),
    .wb_value  (p_wbval),
    .undef_hit (p_undef),
    .nop_hit   (p_nop)
  );

  shl_extend u_extend (
    .half   (mem_rsp_data),
    .narrow (q_narrow),
    .value  (rf_wdata)
  );

  assign op_ready = (state == ST_IDLE);
  assign accept   = op_valid && op_ready;
  assign trap_hit = a_misalign || p_undef || p_nop;
  assign commit   = (state == ST_WAIT) && mem_rsp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      q_addr   <= '0;
      q_wbval  <= '0;
      q_rt     <= '0;
      q_rn     <= '0;
      q_dowb   <= 1'b0;
      q_spsel  <= 1'b0;
      q_narrow <= 1'b0;
      q_priv   <= 1'b0;
      q_tag    <= 1'b0;
      q_falign <= 1'b0;
      q_fundef <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            q_addr   <= a_acc;
            q_wbval  <= p_wbval;
            q_rt     <= op_rt;
            q_rn     <= op_rn;
            q_dowb   <= p_dowb;
            q_spsel  <= a_spsel;
            q_narrow <= op_narrow;
            q_priv   <= a_priv;
            q_tag    <= a_tag;
            q_falign <= a_misalign;
            q_fundef <= p_undef;
            state    <= trap_hit ? ST_FIN : ST_REQ;
          end
        end
        ST_REQ:  if (mem_req_ready) state <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (state == ST_REQ);
  assign mem_req_addr  = q_addr;
  assign mem_req_priv  = q_priv;
  assign mem_req_tag   = q_tag;

  assign rf_we    = commit;
  assign rf_waddr = q_rt;
  assign wb_we    = commit && q_dowb && !q_spsel;
  assign wb_waddr = q_rn;
  assign wb_wdata = q_wbval;
  assign sp_we    = commit && q_dowb && q_spsel;
  assign sp_wdata = q_wbval;

  assign done        = commit || (state == ST_FIN);
  assign fault_align = (state == ST_FIN) && q_falign;
  assign fault_undef = (state == ST_FIN) && q_fundef;
endmodule

// File: rtl/shl_checker.sv
module shl_checker #(
  parameter int         IDX_W  = 5,
  parameter logic [1:0] POLICY = 2'd0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic             op_ready,
  input logic             accept,
  input logic             trap_hit,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [63:0]      mem_req_addr,
  input logic             mem_rsp_valid,
  input logic             done,
  input logic             rf_we,
  input logic [IDX_W-1:0] rf_waddr,
  input logic             wb_we,
  input logic [IDX_W-1:0] wb_waddr,
  input logic             sp_we,
  input logic             fault_align,
  input logic             fault_undef
);
  // R13
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R13
  write_in_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we || wb_we || sp_we) |-> mem_rsp_valid && done);

  // R13
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !op_ready);

  // R6
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_align || fault_undef) |-> !(rf_we || wb_we || sp_we || mem_req_valid) && done);

  // R12
  trap_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && trap_hit |=> done && !mem_req_valid);

  // R5
  one_base_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wb_we && sp_we));

  // R9
  overlap_suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (POLICY != 2'd1) && wb_we |-> wb_waddr != rf_waddr);

  // R14
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |-> op_ready && !mem_req_valid && !rf_we && !(op_valid && !op_ready));
endmodule

bind shload_unit shl_checker #(.IDX_W(IDX_W), .POLICY(OVERLAP_POLICY)) u_chk (.*);

// File: tb/shload_unit_tb.sv
`timescale 1ns/1ps
module shload_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        op_valid = 0, op_narrow = 0;
  logic [4:0]  op_rt = 0, op_rn = 0;
  logic [11:0] op_imm = 0;
  logic [1:0]  op_form = 0, op_el = 0;
  logic [63:0] gpr [0:31];
  logic [63:0] sp_val = 0;
  logic        mem_req_ready = 0, mem_rsp_valid = 0;
  logic [15:0] mem_rsp_data = 0;

  logic        op_ready, mem_req_valid, mem_req_priv, mem_req_tag;
  logic [4:0]  rf_raddr, rf_waddr, wb_waddr;
  logic [63:0] rf_rdata, mem_req_addr, rf_wdata, wb_wdata, sp_wdata;
  logic        rf_we, wb_we, sp_we, done, fault_align, fault_undef;

  assign rf_rdata = gpr[rf_raddr];

  shload_unit #(.OVERLAP_POLICY(2'd0)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_rt(op_rt), .op_rn(op_rn), .op_imm(op_imm), .op_form(op_form),
    .op_narrow(op_narrow), .op_el(op_el), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .sp_rdata(sp_val), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_priv(mem_req_priv), .mem_req_tag(mem_req_tag),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .wb_we(wb_we), .wb_waddr(wb_waddr), .wb_wdata(wb_wdata),
    .sp_we(sp_we), .sp_wdata(sp_wdata), .done(done),
    .fault_align(fault_align), .fault_undef(fault_undef));

  // Copies with the other overlap policies: 1 all-ones, 2 undefined, 3 no-op
  logic        alt_ready [1:3], alt_req_v [1:3], alt_priv [1:3], alt_tag [1:3];
  logic [4:0]  alt_raddr [1:3], alt_rf_waddr [1:3], alt_wb_waddr [1:3];
  logic [63:0] alt_req_addr [1:3], alt_rf_wdata [1:3], alt_wb_wdata [1:3], alt_sp_wdata [1:3];
  logic        alt_rf_we [1:3], alt_wb_we [1:3], alt_sp_we [1:3];
  logic        alt_done [1:3], alt_falign [1:3], alt_fundef [1:3];

  for (genvar k = 1; k <= 3; k++) begin : g_alt
    shload_unit #(.OVERLAP_POLICY(2'(k))) u_alt (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(alt_ready[k]),
      .op_rt(op_rt), .op_rn(op_rn), .op_imm(op_imm), .op_form(op_form),
      .op_narrow(op_narrow), .op_el(op_el), .rf_raddr(alt_raddr[k]), .rf_rdata(rf_rdata),
      .sp_rdata(sp_val), .mem_req_valid(alt_req_v[k]), .mem_req_ready(mem_req_ready),
      .mem_req_addr(alt_req_addr[k]), .mem_req_priv(alt_priv[k]), .mem_req_tag(alt_tag[k]),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .rf_we(alt_rf_we[k]), .rf_waddr(alt_rf_waddr[k]), .rf_wdata(alt_rf_wdata[k]),
      .wb_we(alt_wb_we[k]), .wb_waddr(alt_wb_waddr[k]), .wb_wdata(alt_wb_wdata[k]),
      .sp_we(alt_sp_we[k]), .sp_wdata(alt_sp_wdata[k]), .done(alt_done[k]),
      .fault_align(alt_falign[k]), .fault_undef(alt_fundef[k]));
  end

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic chk_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [4:0] rt, input logic [4:0] rn, input logic [11:0] imm,
                        input logic [1:0] form, input logic narrow, input logic [1:0] el,
                        input logic [15:0] hw);
    logic [63:0] base, off, exp_addr, exp_wb, exp_data;
    bit indexed, ovl, bad, fin, seen;
    int cnt;
    base     = (rn == 5'd31) ? sp_val : gpr[rn];
    off      = (form == 2'd2) ? (64'(imm) << 1) : 64'($signed(imm[8:0]));
    exp_wb   = base + off;
    exp_addr = (form == 2'd0) ? base : exp_wb;
    indexed  = (form != 2'd2);
    ovl      = indexed && rn == rt && rn != 5'd31;
    bad      = rn == 5'd31 && base[3:0] != 4'd0;
    exp_data = narrow ? {32'h0, 32'($signed(hw))} : 64'($signed(hw));

    @(negedge clk);
    mem_rsp_valid = 0;
    mem_req_ready = 0;
    chk_eq("R13 idle before op", op_ready, 1);
    op_rt = rt; op_rn = rn; op_imm = imm; op_form = form; op_narrow = narrow; op_el = el;
    op_valid = 1;
    fin = 0; seen = 0; cnt = 0;
    for (int c = 0; c < 64 && !fin; c++) begin
      @(negedge clk);
      op_valid = 0;
      mem_rsp_valid = 0;
      mem_req_ready = 0;
      if (c == 0) begin
        chk_eq("R13 busy", op_ready, 0);
        if (ovl) begin
          chk_eq("R11 undef policy", {alt_done[2], alt_fundef[2], alt_req_v[2], alt_rf_we[2]}, 4'b1100);
          chk_eq("R12 nop policy", {alt_done[3], alt_fundef[3], alt_falign[3], alt_req_v[3], alt_rf_we[3]}, 5'b10000);
        end
      end
      if (bad) begin
        chk_eq("R6 misaligned sp", {done, fault_align, fault_undef, mem_req_valid, rf_we, wb_we, sp_we}, 7'b1100000);
        fin = 1;
      end else if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          mem_rsp_valid = 1;
          mem_rsp_data = hw;
          #1;
          chk_eq("R13 done on response", done, 1);
          chk_eq("R3 dest index", {rf_we, rf_waddr}, {1'b1, rt});
          chk_eq("R3 extended data", rf_wdata, exp_data);
          if (ovl) begin
            chk_eq("R9 suppressed writeback", {wb_we, sp_we}, 2'b00);
            chk_eq("R10 all-ones writeback", {alt_wb_we[1], alt_wb_waddr[1]}, {1'b1, rn});
            chk_eq("R10 all-ones value", alt_wb_wdata[1], 64'hFFFF_FFFF_FFFF_FFFF);
          end else if (indexed && rn == 5'd31) begin
            chk_eq("R5 sp writeback port", {sp_we, wb_we}, 2'b10);
            chk_eq("R5 sp writeback value", sp_wdata, exp_wb);
          end else if (indexed) begin
            chk_eq("R4 base writeback", {wb_we, wb_waddr, sp_we}, {1'b1, rn, 1'b0});
            chk_eq("R4 writeback value", wb_wdata, exp_wb);
          end else begin
            chk_eq("R4 no writeback", {wb_we, sp_we}, 2'b00);
          end
          fin = 1;
        end
      end else if (mem_req_valid) begin
        if (!seen) begin
          chk_eq((form == 2'd2 || imm[8]) ? "R2 offset address" : "R1 access address", mem_req_addr, exp_addr);
          chk_eq("R8 privileged", mem_req_priv, el != 2'd0);
          chk_eq("R7 tag checked", mem_req_tag, indexed || rn != 5'd31);
          seen = 1;
        end
        mem_req_ready = ($urandom % 3) != 0;
        if (mem_req_ready) cnt = 1 + ($urandom % 3);
      end
    end
    if (!fin) chk_eq("R13 completion", 0, 1);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) gpr[i] = 64'h0;
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    chk_eq("R14 reset idle", {op_ready, mem_req_valid, done, rf_we, wb_we, sp_we}, 6'b100000);
    rst_n = 1;

    gpr[3] = 64'h1000;
    run_op(5'd7, 5'd3, 12'h0FF, 2'd0, 1'b0, 2'd1, 16'h8001);      // post-index, +255
    gpr[4] = 64'h2000;
    run_op(5'd8, 5'd4, 12'hF00, 2'd1, 1'b1, 2'd0, 16'hFFFE);      // pre-index, -256, upper imm bits ignored
    gpr[9] = 64'h10000;
    run_op(5'd1, 5'd9, 12'hFFF, 2'd2, 1'b1, 2'd3, 16'h7FFF);      // unsigned offset 8190
    sp_val = 64'h8000;
    run_op(5'd2, 5'd31, 12'h010, 2'd1, 1'b0, 2'd2, 16'h8000);     // sp base, indexed
    run_op(5'd6, 5'd31, 12'h005, 2'd2, 1'b0, 2'd0, 16'h1234);     // sp base, untagged
    sp_val = 64'h8008;
    run_op(5'd6, 5'd31, 12'h005, 2'd0, 1'b0, 2'd1, 16'h1234);     // misaligned sp
    gpr[5] = 64'h3000;
    run_op(5'd5, 5'd5, 12'h020, 2'd1, 1'b0, 2'd1, 16'h9ABC);      // overlap, pre-index
    gpr[30] = 64'h4000;
    run_op(5'd30, 5'd30, 12'h1F0, 2'd0, 1'b1, 2'd0, 16'h00FF);    // overlap, post-index

    for (int n = 0; n < 400; n++) begin
      logic [4:0] rt, rn;
      rn = 5'($urandom % 32);
      rt = (($urandom % 6) == 0) ? rn : 5'($urandom % 32);
      gpr[rn] = {$urandom, $urandom};
      sp_val = {$urandom, $urandom};
      if (($urandom % 4) != 0) sp_val[3:0] = 4'd0;
      run_op(rt, rn, 12'($urandom), 2'($urandom % 3), 1'($urandom), 2'($urandom), 16'($urandom));
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R13 watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule